// File: doc/BRIEF.md
# Upcounting Time Base with Staged Prescaler

This block is a timer time base. A programmable prescaler divides the input clock and produces count ticks. An upcounter advances on each tick until it reaches an auto-reload limit. It then returns to zero and flags an overflow. A repetition stage groups a number of overflows into one update event.

All three settings (division, limit and repetition) are written through a small register-write port into staging copies. The settings in use change only when an update event occurs. Software can therefore rewrite several settings and have them take effect together at a period boundary.

A control word has three bits. One starts and stops counting. One blocks updates caused by overflows. A write-one strobe forces an update at once. The block outputs the running count, an overflow pulse and an update pulse, each one clock wide.

Top module: `upcount_timebase`

## Requirements
- R1: After reset the count output is 0, both pulses are low, and every register (control, staging and active) is zero. The count stays at 0 until counting is enabled.
- R2: With active division setting P and active limit A, the count shows floor(k/(P+1)) mod (A+1), k clocks after an update that leaves the block enabled. The overflow output is high for one cycle whenever k is a nonzero multiple of (P+1)(A+1), and that is the cycle in which the count shows 0.
- R3: With active repetition setting R, the update output pulses for one cycle at k equal to each nonzero multiple of (P+1)(A+1)(R+1). With R = 0, every overflow is also an update.
- R4: Writing 1 to control bit 2 at address 0 forces an update. In the next cycle the update output is high and the count is 0, whatever the repetition progress and the update-block bit are. The prescaler restarts from zero.
- R5: While control bit 1 is set, overflows still pulse the overflow output. They produce no update, and the active limit, division and repetition settings keep their values.
- R6: Writes to the staging registers change nothing in the running period: address 1 holds the division, address 2 the limit and address 3 the repetition. The staged values become active at the next update, and the new division applies from the first tick after that update.
- R7: While control bit 0 (enable) is clear, the count holds its value and no overflow occurs.
- R8: With an active limit of 0, the count stays at 0 and an overflow occurs on every prescaled tick.
- R9: The write port decodes a 2-bit address. Address 0 is control: bit 0 enable, bit 1 update block, bit 2 update strobe (not stored). Addresses 1, 2 and 3 are the division, limit and repetition staging registers, taken from the low bits of the data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | 2 | Register address (0 control, 1 division, 2 limit, 3 repetition) |
| wr_data | input | DATA_W (16) | Write data |
| count | output | CNT_W (16) | Current counter value |
| ovf_pulse | output | 1 | One-cycle overflow indication |
| upd_pulse | output | 1 | One-cycle update-event indication |

## Verification
The assertions assume that `wr_en` is a one-cycle strobe that is low around reset. They also assume that staged values fit the widths of the active registers. The stimulus writes only through a task that raises `wr_en` for exactly one clock and keeps every value small.

The sweep reprograms the block only while it is disabled, and then starts each configuration with a forced update. The arithmetic expectation therefore always starts from a known zero phase. The directed cases then change settings while the block runs. For those cases the bench checks window properties (maximum count, pulse counts, step size) rather than exact cycles.

// File: rtl/timebase_pkg.sv
package timebase_pkg;
  localparam int unsigned ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_CTRL  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_DIV   = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_LIMIT = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_REP   = 2'd3;

  localparam int unsigned BIT_EN   = 0;
  localparam int unsigned BIT_UBLK = 1;
  localparam int unsigned BIT_FORCE = 2;

  typedef struct packed {
    logic enable;
    logic upd_block;
  } ctrl_t;
endpackage

// File: rtl/timebase_regs.sv
module timebase_regs
  import timebase_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned PSC_W  = 16,
  parameter int unsigned REP_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              upd_evt,
  output logic              enable,
  output logic              upd_block,
  output logic              force_upd,
  output logic [PSC_W-1:0]  div_act,
  output logic [CNT_W-1:0]  lim_act,
  output logic [REP_W-1:0]  rep_act
);
  ctrl_t             ctrl_q, ctrl_d;
  logic [PSC_W-1:0]  div_stg_q, div_stg_d;
  logic [CNT_W-1:0]  lim_stg_q, lim_stg_d;
  logic [REP_W-1:0]  rep_stg_q, rep_stg_d;
  logic [PSC_W-1:0]  div_act_q;
  logic [CNT_W-1:0]  lim_act_q;
  logic [REP_W-1:0]  rep_act_q;

  logic sel_ctrl, sel_div, sel_lim, sel_rep;

  assign sel_ctrl = wr_en && (wr_addr == ADDR_CTRL);
  assign sel_div  = wr_en && (wr_addr == ADDR_DIV);
  assign sel_lim  = wr_en && (wr_addr == ADDR_LIMIT);
  assign sel_rep  = wr_en && (wr_addr == ADDR_REP);

  assign force_upd = sel_ctrl && wr_data[BIT_FORCE];

  always_comb begin
    ctrl_d           = ctrl_q;
    ctrl_d.enable    = wr_data[BIT_EN];
    ctrl_d.upd_block = wr_data[BIT_UBLK];
    div_stg_d        = wr_data[PSC_W-1:0];
    lim_stg_d        = wr_data[CNT_W-1:0];
    rep_stg_d        = wr_data[REP_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      div_stg_q <= '0;
      lim_stg_q <= '0;
      rep_stg_q <= '0;
    end else begin
      if (sel_ctrl) ctrl_q    <= ctrl_d;
      if (sel_div)  div_stg_q <= div_stg_d;
      if (sel_lim)  lim_stg_q <= lim_stg_d;
      if (sel_rep)  rep_stg_q <= rep_stg_d;
    end
  end

  // Active copies load from staging only on an update event.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_act_q <= '0;
      lim_act_q <= '0;
      rep_act_q <= '0;
    end else if (upd_evt) begin
      div_act_q <= div_stg_q;
      lim_act_q <= lim_stg_q;
      rep_act_q <= rep_stg_q;
    end
  end

  assign enable    = ctrl_q.enable;
  assign upd_block = ctrl_q.upd_block;
  assign div_act   = div_act_q;
  assign lim_act   = lim_act_q;
  assign rep_act   = rep_act_q;

  // R6: a staging write without an update leaves the active copies untouched
  assert_stage_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_addr != ADDR_CTRL) && !upd_evt) |=>
      ($stable(div_act_q) && $stable(lim_act_q) && $stable(rep_act_q)));
endmodule

// File: rtl/timebase_presc.sv
module timebase_presc #(
  parameter int unsigned PSC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             restart,
  input  logic [PSC_W-1:0] div_act,
  output logic             tick
);
  logic [PSC_W-1:0] pc_q, pc_d;
  logic             pc_ce;
  logic             at_end;

  assign at_end = (pc_q == div_act);
  assign tick   = enable && at_end;
  assign pc_ce  = enable || restart;

  always_comb begin
    if (restart || at_end) pc_d = '0;
    else                   pc_d = pc_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pc_q <= '0;
    else if (pc_ce) pc_q <= pc_d;
  end

  // R2: the prescaler phase never passes the active division setting
  assert_phase_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pc_q <= div_act);

  // R4: an update restarts the prescaler phase
  assert_phase_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (pc_q == '0));
endmodule

// File: rtl/timebase_count.sv
module timebase_count #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned REP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             force_upd,
  input  logic             upd_block,
  input  logic [CNT_W-1:0] lim_act,
  input  logic [REP_W-1:0] rep_act,
  output logic             upd_evt,
  output logic [CNT_W-1:0] count,
  output logic             ovf_pulse,
  output logic             upd_pulse
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [REP_W-1:0] rep_q, rep_d;
  logic             cnt_ce, rep_ce;
  logic             wrap, rep_last;
  logic             ovf_q, upd_q;

  assign wrap     = tick && (cnt_q == lim_act);
  assign rep_last = (rep_q == rep_act);
  assign upd_evt  = force_upd || (wrap && !upd_block && rep_last);

  assign cnt_ce = tick || upd_evt;
  assign rep_ce = upd_evt || (wrap && !upd_block);

  always_comb begin
    if (upd_evt || wrap) cnt_d = '0;
    else                 cnt_d = cnt_q + 1'b1;
  end

  always_comb begin
    if (upd_evt) rep_d = '0;
    else         rep_d = rep_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rep_q <= '0;
    else if (rep_ce) rep_q <= rep_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q <= 1'b0;
      upd_q <= 1'b0;
    end else begin
      ovf_q <= wrap;
      upd_q <= upd_evt;
    end
  end

  assign count     = cnt_q;
  assign ovf_pulse = ovf_q;
  assign upd_pulse = upd_q;

  // R2: the count never exceeds the active limit
  assert_within_limit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= lim_act);

  // R2: an overflow pulse coincides with a count of zero
  assert_ovf_at_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |-> (cnt_q == '0));

  // R3: repetition progress stays within the active repetition setting
  assert_rep_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rep_q <= rep_act);

  // R4: a forced update pulses the output and clears the count
  assert_force_R4: assert property (@(posedge clk) disable iff (!rst_n)
    force_upd |=> (upd_q && (cnt_q == '0)));

  // R5: a blocked overflow produces no update
  assert_blocked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && upd_block && !force_upd) |=> !upd_q);

  // R7: without a tick or an update the count holds
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !upd_evt) |=> $stable(cnt_q));

  // R8: a zero limit pins the count to zero
  assert_zero_limit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (lim_act == '0) |-> (cnt_q == '0));
endmodule

// File: rtl/upcount_timebase.sv
module upcount_timebase
  import timebase_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned PSC_W  = 16,
  parameter int unsigned REP_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [CNT_W-1:0]  count,
  output logic              ovf_pulse,
  output logic              upd_pulse
);
  logic             enable, upd_block, force_upd, upd_evt, tick;
  logic [PSC_W-1:0] div_act;
  logic [CNT_W-1:0] lim_act;
  logic [REP_W-1:0] rep_act;

  timebase_regs #(
    .DATA_W(DATA_W), .CNT_W(CNT_W), .PSC_W(PSC_W), .REP_W(REP_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .upd_evt(upd_evt),
    .enable(enable), .upd_block(upd_block), .force_upd(force_upd),
    .div_act(div_act), .lim_act(lim_act), .rep_act(rep_act)
  );

  timebase_presc #(.PSC_W(PSC_W)) u_presc (
    .clk(clk), .rst_n(rst_n),
    .enable(enable), .restart(upd_evt), .div_act(div_act),
    .tick(tick)
  );

  timebase_count #(.CNT_W(CNT_W), .REP_W(REP_W)) u_count (
    .clk(clk), .rst_n(rst_n),
    .tick(tick), .force_upd(force_upd), .upd_block(upd_block),
    .lim_act(lim_act), .rep_act(rep_act),
    .upd_evt(upd_evt),
    .count(count), .ovf_pulse(ovf_pulse), .upd_pulse(upd_pulse)
  );

  // R1: outputs are quiet while reset is held
  always_comb begin
    if (!rst_n) assert_reset_quiet_R1: assert (count == '0 && !ovf_pulse && !upd_pulse);
  end

  // R9: widths of the active registers fit the write data
  initial begin
    assert_widths_R9: assert (CNT_W <= DATA_W && PSC_W <= DATA_W && REP_W <= DATA_W);
  end
endmodule

// File: tb/upcount_timebase_tb.sv
module upcount_timebase_tb;
  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [1:0]  wr_addr;
  logic [15:0] wr_data;
  logic [15:0] count;
  logic        ovf_pulse;
  logic        upd_pulse;

  int checks;
  int failures;

  upcount_timebase u_dut (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .count(count), .ovf_pulse(ovf_pulse), .upd_pulse(upd_pulse)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input int addr, input int data);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_addr = addr[1:0];
    wr_data = data[15:0];
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  // Programs a configuration while disabled, then starts it with a forced update.
  task automatic start_cfg(input int p, input int a, input int r);
    wr(0, 0);
    wr(1, p);
    wr(2, a);
    wr(3, r);
    wr(0, 5);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int v, mx, nu, no, prev;
    checks = 0; failures = 0;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state and idle while disabled
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check("R1 count", count, 0);
      check("R1 ovf", ovf_pulse, 0);
      check("R1 upd", upd_pulse, 0);
    end

    // R2 R3 R8 R9: sweep of small configurations
    for (int p = 0; p < 4; p++)
      for (int a = 0; a < 4; a++)
        for (int r = 0; r < 3; r++) begin
          int per, urp, n;
          per = (p + 1) * (a + 1);
          urp = per * (r + 1);
          n   = 2 * urp + 3;
          start_cfg(p, a, r);
          for (int k = 0; k <= n; k++) begin
            check("R2 R9 count", count, (k / (p + 1)) % (a + 1));
            check(a == 0 ? "R8 ovf" : "R2 ovf", ovf_pulse,
                  (k > 0 && k % per == 0) ? 1 : 0);
            check("R3 upd", upd_pulse,
                  (k == 0 || k % urp == 0) ? 1 : 0);
            @(negedge clk);
          end
        end

    // R5: update block keeps the old limit and suppresses updates
    start_cfg(0, 2, 0);
    wr(0, 3);
    wr(2, 5);
    mx = 0; nu = 0; no = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (count > mx) mx = count;
      nu += upd_pulse;
      no += ovf_pulse;
    end
    check("R5 max count with old limit", mx, 2);
    check("R5 no update while blocked", nu, 0);
    check("R5 overflows still seen", (no >= 3) ? 1 : 0, 1);
    // R6: clearing the block lets an overflow update apply the staged limit
    wr(0, 1);
    nu = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      nu += upd_pulse;
    end
    check("R6 update after unblock", (nu >= 1) ? 1 : 0, 1);
    mx = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (count > mx) mx = count;
    end
    check("R6 new limit in effect", mx, 5);

    // R6: a mid-period division write keeps the old division
    start_cfg(0, 15, 0);
    wr(1, 3);
    for (int i = 0; i < 4; i++) begin
      prev = count;
      @(negedge clk);
      check("R6 old division kept", count, prev + 1);
    end
    wr(0, 5);
    for (int k = 0; k <= 12; k++) begin
      if (k == 0) check("R4 forced update pulse", upd_pulse, 1);
      check("R6 new division after update", count, k / 4);
      @(negedge clk);
    end

    // R4: forced update while updates are blocked
    wr(0, 7);
    check("R4 forced pulse under block", upd_pulse, 1);
    check("R4 count cleared", count, 0);

    // R7: disabling holds the count
    repeat (5) @(negedge clk);
    wr(0, 0);
    v = count;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check("R7 count held", count, v);
      check("R7 no overflow", ovf_pulse, 0);
    end

    // R8: zero limit with division 2
    start_cfg(1, 0, 0);
    for (int k = 0; k <= 8; k++) begin
      check("R8 count zero", count, 0);
      check("R8 ovf every tick", ovf_pulse, (k > 0 && k % 2 == 0) ? 1 : 0);
      @(negedge clk);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule